// File: doc/BRIEF.md
# Indexed Vector Memory Access Sequencer

This block carries out one indexed vector memory operation: a gather (load) or a scatter (store). It turns the operation into a series of single-word accesses on a plain valid/ready memory port. A command supplies four things: a scalar byte base address, a packed vector of unsigned element indices, a packed vector of store data and a per-element enable mask. For each enabled element the sequencer forms the byte address base + 4 × index and issues one scalar request. Elements go out one at a time, in ascending element order.

For a gather, the sequencer waits for each read response before it issues the next request. Only one access is ever outstanding. The returned word goes into the matching lane of a destination vector register, and lanes that are not enabled keep their earlier contents. A scatter completes an element when its write request is accepted. Once the last enabled element has completed, the sequencer pulses `done` and returns to idle. While a command is running, `busy` is high and new commands are ignored.

The control is a four-state machine:
- `S_IDLE` waits for a command.
- `S_ISSUE` drives a request until it is accepted.
- `S_WAIT` waits for a read response.
- `S_DONE` produces the completion pulse.

The transitions are:
- `S_IDLE`→`S_ISSUE` when a command is accepted with at least one lane enabled.
- `S_IDLE`→`S_DONE` when a command is accepted with no lane enabled.
- `S_ISSUE`→`S_WAIT` when a read request is accepted.
- `S_ISSUE`→`S_ISSUE` when a write is accepted and lanes remain.
- `S_ISSUE`→`S_DONE` when a write is accepted and it was the last lane.
- `S_WAIT`→`S_ISSUE` when a response arrives and lanes remain.
- `S_WAIT`→`S_DONE` when a response arrives for the last lane.
- `S_DONE`→`S_IDLE` always, after one cycle.

Top module: `vgs_seq`

## Requirements
- R1: The request address for element i is `cmd_base + (index_i << 2)`, where index_i is bits [16i+15:16i] of `cmd_index`, zero-extended.
- R2: Exactly one request is issued per element whose bit i of `cmd_mask` is 1, in ascending element order. Elements with mask 0 issue no request. When two scatter elements share an address, the higher element's data is what remains in memory.
- R3: On a scatter (`cmd_store`=1), every request has `mem_req_write`=1, and `mem_req_wdata` is bits [32i+31:32i] of `cmd_wdata`. On a gather every request has `mem_req_write`=0.
- R4: On a gather, the response word for element i is written into bits [32i+31:32i] of `dst_vec`. Lanes with mask 0 keep their earlier value. A scatter leaves `dst_vec` unchanged.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid in the next cycle with unchanged address, data and write flag.
- R6: `done` is high for exactly one cycle: the cycle after the clock edge at which the last element completed. A write completes when it is accepted; a read completes when its response is sampled. With an all-zero mask, `done` is high in the cycle after the command was accepted.
- R7: `busy` is high from the cycle after a command is accepted through the `done` cycle. A command presented while `busy` is high is ignored and issues no request.
- R8: After reset, `busy`, `done` and `mem_req_valid` are 0 and `dst_vec` is 0.
- R9: After a read request is accepted, no new request is issued until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present (taken when busy is low) |
| cmd_store | input | 1 | 1 = scatter, 0 = gather |
| cmd_base | input | 32 | Scalar byte base address |
| cmd_index | input | 64 | Four packed 16-bit element indices |
| cmd_wdata | input | 128 | Four packed 32-bit store words |
| cmd_mask | input | 4 | Per-element enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_vec | output | 128 | Gather destination vector |
| mem_req_valid | output | 1 | Scalar request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Request write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |

## Verification
The assertions assume the memory behaves in order. It returns exactly one read response for each accepted read, never in the same cycle as the acceptance, and it raises no response while no read is outstanding. They also assume commands arrive only from outside the running operation.

The bench's memory model keeps to these rules. It sends each response one to three cycles after the read is accepted, holds it for a single cycle, and picks `mem_req_ready` at random. Commands are driven only while `busy` is low, apart from one deliberate ignored command that is sent mid-operation.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } vgs_state_e;
endpackage

// File: rtl/vgs_pick.sv
// Lowest-pending-element selector: one-hot grant and binary index.
module vgs_pick #(
    parameter int N   = 4,
    localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   pend,
    output logic [N-1:0]   grant,
    output logic [IXW-1:0] sel,
    output logic           any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]  = pend[g] & ~seen[g];
        assign seen[g+1] = seen[g] | pend[g];
    end
    assign any = seen[N];

    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) sel = IXW'(i);
        end
    end

    // R2: the grant is one of the pending lanes and at most one lane
    p_pick_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~pend) == '0) && $onehot0(grant) && (any == (pend != '0)));
endmodule

// File: rtl/vgs_addr.sv
// Forms the byte address of the selected element: base + index scaled.
module vgs_addr #(
    parameter int N      = 4,
    parameter int AW     = 32,
    parameter int IW     = 16,
    parameter int ESHIFT = 2,
    localparam int IXW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [AW-1:0]   base,
    input  logic [N*IW-1:0] index_vec,
    input  logic [IXW-1:0]  sel,
    output logic [AW-1:0]   addr
);
    logic [IW-1:0] lane_idx;
    logic [AW-1:0] offset;

    assign lane_idx = index_vec[sel*IW +: IW];
    assign offset   = AW'(lane_idx) << ESHIFT;
    assign addr     = base + offset;
endmodule

// File: rtl/vgs_collect.sv
// Destination vector register: one lane written per gather response.
module vgs_collect #(
    parameter int N   = 4,
    parameter int DW  = 32,
    localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IXW-1:0]  wr_sel,
    input  logic [DW-1:0]   wr_data,
    output logic [N*DW-1:0] vec
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec[g*DW +: DW] <= '0;
            end else if (wr_en && (wr_sel == IXW'(g))) begin
                vec[g*DW +: DW] <= wr_data;
            end
        end
    end

    // R4: a write only changes the addressed lane
    p_lane_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((vec ^ $past(vec)) & ~({{(N-1)*DW{1'b0}}, {DW{1'b1}}} << ($past(wr_sel) * DW))) == '0);
endmodule

// File: rtl/vgs_seq.sv
module vgs_seq
    import vgs_pkg::*;
#(
    parameter int N      = 4,
    parameter int AW     = 32,
    parameter int IW     = 16,
    parameter int DW     = 32,
    parameter int ESHIFT = 2,
    localparam int IXW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic            cmd_store,
    input  logic [AW-1:0]   cmd_base,
    input  logic [N*IW-1:0] cmd_index,
    input  logic [N*DW-1:0] cmd_wdata,
    input  logic [N-1:0]    cmd_mask,
    output logic            busy,
    output logic            done,
    output logic [N*DW-1:0] dst_vec,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_write,
    output logic [AW-1:0]   mem_req_addr,
    output logic [DW-1:0]   mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data
);
    vgs_state_e state_q, state_d;

    logic            op_store_q;
    logic [AW-1:0]   base_q;
    logic [N*IW-1:0] index_q;
    logic [N*DW-1:0] wdata_q;
    logic [N-1:0]    pend_q;

    logic [N-1:0]    grant;
    logic [IXW-1:0]  cur_sel;
    logic            pend_any;
    logic [N-1:0]    pend_next;
    logic            accept;
    logic            elem_done;
    logic            rsp_take;

    assign accept    = cmd_valid && (state_q == S_IDLE);
    assign rsp_take  = (state_q == S_WAIT) && mem_rsp_valid;
    assign elem_done = ((state_q == S_ISSUE) && mem_req_ready && op_store_q) || rsp_take;
    assign pend_next = pend_q & ~grant;

    vgs_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_q),
        .grant (grant),
        .sel   (cur_sel),
        .any   (pend_any)
    );

    vgs_addr #(.N(N), .AW(AW), .IW(IW), .ESHIFT(ESHIFT)) u_addr (
        .base      (base_q),
        .index_vec (index_q),
        .sel       (cur_sel),
        .addr      (mem_req_addr)
    );

    vgs_collect #(.N(N), .DW(DW)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rsp_take),
        .wr_sel  (cur_sel),
        .wr_data (mem_rsp_data),
        .vec     (dst_vec)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) state_d = (cmd_mask != '0) ? S_ISSUE : S_DONE;
            end
            S_ISSUE: begin
                if (mem_req_ready) begin
                    if (!op_store_q)           state_d = S_WAIT;
                    else if (pend_next != '0)  state_d = S_ISSUE;
                    else                       state_d = S_DONE;
                end
            end
            S_WAIT: begin
                if (mem_rsp_valid) state_d = (pend_next != '0) ? S_ISSUE : S_DONE;
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_store_q <= 1'b0;
            base_q     <= '0;
            index_q    <= '0;
            wdata_q    <= '0;
            pend_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_store_q <= cmd_store;
                base_q     <= cmd_base;
                index_q    <= cmd_index;
                wdata_q    <= cmd_wdata;
                pend_q     <= cmd_mask;
            end else if (elem_done) begin
                pend_q <= pend_next;
            end
        end
    end

    // Outputs
    always_comb begin
        busy          = (state_q != S_IDLE);
        done          = (state_q == S_DONE);
        mem_req_valid = (state_q == S_ISSUE);
        mem_req_write = op_store_q;
        mem_req_wdata = wdata_q[cur_sel*DW +: DW];
    end

    // R5: an unaccepted request is held steady
    p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write)));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the last completing element leads straight to done
    p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done && (pend_next == '0)) |=> done);

    // R7: done only occurs while busy, and busy follows acceptance
    p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R9: an accepted read blocks further requests in the next cycle
    p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid);

    // R2: elements finish in ascending order
    p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done && (pend_next != '0)) |=> (cur_sel > $past(cur_sel)));

    // R2: a request always belongs to a pending lane
    p_req_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> pend_any);
endmodule

// File: tb/tb_vgs_seq.sv
module tb_vgs_seq;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int IW = 16;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_store = 1'b0;
    logic [AW-1:0]   cmd_base = '0;
    logic [N*IW-1:0] cmd_index = '0;
    logic [N*DW-1:0] cmd_wdata = '0;
    logic [N-1:0]    cmd_mask = '0;
    logic            busy, done;
    logic [N*DW-1:0] dst_vec;
    logic            mem_req_valid, mem_req_write;
    logic            mem_req_ready = 1'b0;
    logic [AW-1:0]   mem_req_addr;
    logic [DW-1:0]   mem_req_wdata;
    logic            mem_rsp_valid = 1'b0;
    logic [DW-1:0]   mem_rsp_data = '0;

    vgs_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_base(cmd_base), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
        .cmd_mask(cmd_mask), .busy(busy), .done(done), .dst_vec(dst_vec),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int ncyc = 0;

    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] log_addr [0:15];
    logic          log_wr   [0:15];
    logic [DW-1:0] log_data [0:15];
    int            log_n = 0;
    int            last_cmp = 0;
    int            done_cnt = 0;
    int            done_cyc = 0;
    int            rd_wait = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [N*DW-1:0] exp_vec = '0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) ncyc <= ncyc + 1;

    // Memory model and monitor, all at the falling edge
    always @(negedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (done) begin
            done_cnt = done_cnt + 1;
            done_cyc = ncyc;
        end
        if (rd_wait > 0) begin
            rd_wait = rd_wait - 1;
            if (rd_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[rd_addr[9:2]];
                last_cmp      = ncyc + 1;
            end
        end
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
            if (log_n < 16) begin
                log_addr[log_n] = mem_req_addr;
                log_wr[log_n]   = mem_req_write;
                log_data[log_n] = mem_req_wdata;
            end
            log_n = log_n + 1;
            if (mem_req_write) begin
                mem[mem_req_addr[9:2]] = mem_req_wdata;
                last_cmp = ncyc + 1;
            end else begin
                rd_addr = mem_req_addr;
                rd_wait = 1 + int'($urandom % 3);
            end
        end
    end

    task automatic run_cmd(input bit st, input logic [AW-1:0] b, input logic [N*IW-1:0] ix,
                           input logic [N*DW-1:0] wd, input logic [N-1:0] m, input bit poke);
        logic [AW-1:0] ea [0:N-1];
        logic [DW-1:0] ed [0:N-1];
        int en;
        int t;
        en = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                ea[en] = b + ({16'd0, ix[i*IW +: IW]} << 2);
                ed[en] = wd[i*DW +: DW];
                if (!st) exp_vec[i*DW +: DW] = mem[ea[en][9:2]];
                en++;
            end
        end
        log_n = 0;
        done_cnt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = st; cmd_base = b;
        cmd_index = ix; cmd_wdata = wd; cmd_mask = m;
        last_cmp = ncyc + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R7 busy after accept", 128'(busy), 128'd1);
        if (poke) begin
            cmd_valid = 1'b1; cmd_store = ~st; cmd_base = b + 32'h100; cmd_mask = '1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 300) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        check(done_cnt == 1, "R6 one done pulse", 128'(done_cnt), 128'd1);
        check(done_cyc == last_cmp, "R6 done timing", 128'(done_cyc), 128'(last_cmp));
        check(busy == 1'b0, "R7 idle after done", 128'(busy), 128'd0);
        check(log_n == en, "R2 request count", 128'(log_n), 128'(en));
        for (int k = 0; k < en && k < log_n; k++) begin
            check(log_addr[k] == ea[k], "R1 address", 128'(log_addr[k]), 128'(ea[k]));
            check(log_wr[k] == st, "R3 write flag", 128'(log_wr[k]), 128'(st));
            if (st) check(log_data[k] == ed[k], "R3 store data", 128'(log_data[k]), 128'(ed[k]));
        end
        check(dst_vec == exp_vec, "R4 destination vector", dst_vec, exp_vec);
    endtask

    function automatic logic [N*IW-1:0] rnd_idx();
        logic [N*IW-1:0] v;
        for (int i = 0; i < N; i++) v[i*IW +: IW] = 16'($urandom % 128);
        return v;
    endfunction

    function automatic logic [N*DW-1:0] rnd_data();
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = $urandom;
        return v;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) mem[i] = (i * 32'h0101_0101) ^ 32'hA500_0000;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && mem_req_valid == 0, "R8 reset outputs",
              {busy, done, mem_req_valid}, 128'd0);
        check(dst_vec == '0, "R8 reset dst_vec", dst_vec, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: full gather
        run_cmd(1'b0, 32'h40, {16'd3, 16'd2, 16'd1, 16'd0}, '0, 4'b1111, 1'b0);
        // Directed: partial mask gather keeps other lanes (R4)
        run_cmd(1'b0, 32'h80, {16'd9, 16'd8, 16'd7, 16'd6}, '0, 4'b0101, 1'b0);
        // Directed: all masked (R6, R2)
        run_cmd(1'b0, 32'h0, '0, '0, 4'b0000, 1'b0);
        run_cmd(1'b1, 32'h0, '0, rnd_data(), 4'b0000, 1'b0);
        // Directed: duplicate scatter, higher lane wins (R2)
        run_cmd(1'b1, 32'h200, {16'd5, 16'd1, 16'd5, 16'd5}, {32'h4444, 32'h3333, 32'h2222, 32'h1111}, 4'b1111, 1'b0);
        check(mem[(32'h200 + 20) >> 2] == 32'h4444, "R2 higher lane persists",
              128'(mem[(32'h200 + 20) >> 2]), 128'h4444);
        // Directed: last lane only
        run_cmd(1'b1, 32'h300, {16'd127, 16'd0, 16'd0, 16'd0}, rnd_data(), 4'b1000, 1'b0);
        // Directed: command while busy is ignored (R7)
        run_cmd(1'b0, 32'h10, rnd_idx(), '0, 4'b1111, 1'b1);
        run_cmd(1'b1, 32'h20, rnd_idx(), rnd_data(), 4'b1111, 1'b1);
        // Random mix
        for (int r = 0; r < 30; r++) begin
            run_cmd(1'($urandom % 2), 32'(($urandom % 128) * 4), rnd_idx(), rnd_data(),
                    4'($urandom % 16), 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule